// File: doc/BRIEF.md
# UART Transmit Path with Holding FIFO

This block is the transmit side of a UART for 8-bit characters. The host pushes bytes into a holding stage. A control input sets the size of that stage: one byte (single-register mode) or sixteen bytes (FIFO mode). A shift register takes one byte at a time from the holding stage. It sends the byte as an asynchronous serial frame, with each bit lasting sixteen pulses of an oversampling tick that is generated outside the block.

Two status outputs report progress:
- The holding-empty flag says that no bytes are waiting.
- The transmitter-empty flag says that the holding stage is empty and the shift register has also finished its stop bit.

A pending transmit-empty interrupt is latched when the holding stage drains. In FIFO mode it is also latched when the fill level falls below a selectable threshold. The pending bit is gated by an enable input and cleared by a read pulse. A clear-to-send input can hold off the start of new characters.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, txd is 1, hold_empty is 1, xmit_empty is 1 and irq is 0.
- R2: Each character goes out as one frame on txd:
  - a start bit at 0,
  - then 8 data bits, least significant bit first,
  - then a stop bit at 1.
  Each bit lasts 16 cycles in which ovs_tick is 1. When no frame is being sent, txd stays at 1.
- R3: With fifo_en=0 the holding stage holds at most 1 byte. With fifo_en=1 it holds at most 16 bytes. A write (wr_en=1) that finds the stage full is dropped.
- R4: In single-register mode, hold_empty becomes 1 in the same cycle in which the byte leaves the holding register and txd drops for the start bit.
- R5: In FIFO mode, hold_empty is 1 only while the FIFO holds no bytes.
- R6: xmit_empty is 1 only while the holding stage is empty and no frame is in progress. It stays 0 until the stop bit of the last frame has ended.
- R7: In either mode, the interrupt becomes pending in the cycle in which the holding stage goes from non-empty to empty.
- R8: In FIFO mode, the interrupt also becomes pending when the fill count drops from at least L to below L. L is set by trig_sel as follows:

  | trig_sel | L |
  |----------|---|
  | 0 | 4 |
  | 1 | 8 |
  | 2 | 12 |
  | 3 | 14 |

- R9: irq equals the pending bit ANDed with irq_en. The pending bit keeps its value while irq_en is 0.
- R10: A one-cycle isr_rd pulse clears the pending bit. If a new pending event falls in the same cycle, the event wins and the bit stays set.
- R11: While cts_ok is 0, no new frame starts. A frame that is already being sent completes.
- R12: Bytes leave on txd in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovs_tick | input | 1 | Oversampling enable, 16 per bit time |
| fifo_en | input | 1 | 1 selects the 16-byte FIFO, 0 selects the single register |
| trig_sel | input | 2 | FIFO drain threshold select |
| irq_en | input | 1 | Transmit-empty interrupt enable |
| cts_ok | input | 1 | 1 allows a new frame to start |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| isr_rd | input | 1 | Interrupt status read pulse, clears pending |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding stage empty |
| xmit_empty | output | 1 | Holding stage and shift register both empty |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
Two functions can meet in one cycle:
- a drain event that sets the interrupt (the last byte leaving, or the fill count crossing the threshold), and
- an isr_rd pulse that clears it.

A second collision is between a host write and the shift register taking a byte while the single register is full. In that case the write must be dropped, because the byte count is judged before the transfer.

The random phase provokes both collisions. It pulses isr_rd in about a fifth of all cycles, and it writes in bursts while frames drain and while cts_ok toggles. A cycle-accurate bench model, built from the requirements, judges each cycle's txd, flags and irq. A separate serial decoder checks the byte order.

// File: rtl/uart_tx_pkg.sv
// Package: shared types and helpers for the UART transmit path.
// Assumes: the FIFO depth is a multiple of 4 and at least 4.
package uart_tx_pkg;

    // Serializer states
    typedef enum logic {
        SER_IDLE  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_t;

    // Map the threshold select onto a fill level for a FIFO of the given depth
    function automatic int trig_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return depth / 4;
            2'd1:    return depth / 2;
            2'd2:    return (3 * depth) / 4;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/tx_hold_fifo.sv
// Module: holding stage. Circular buffer whose usable capacity is DEPTH
// in FIFO mode and 1 in single-register mode.
// Assumes: pop is requested only while count is non-zero (guarded anyway).
// Exposes the current and next count so that interrupt logic sees drain edges.
module tx_hold_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     count,
    output logic [CW-1:0]     count_nxt
);

    localparam logic [CW-1:0] CAP_FIFO = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_ONE  = CW'(1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     cap;
    logic              push_ok;
    logic              pop_ok;

    // Capacity and acceptance, judged on the count before this edge
    always_comb begin
        cap     = fifo_en ? CAP_FIFO : CAP_ONE;
        push_ok = wr_en && (count < cap);
        pop_ok  = pop && (count != '0);
    end

    // Next fill count from the accepted push and pop
    always_comb begin
        count_nxt = count;
        if (push_ok && !pop_ok) begin
            count_nxt = count + CW'(1);
        end else if (!push_ok && pop_ok) begin
            count_nxt = count - CW'(1);
        end
    end

    assign rd_data = mem[rd_ptr];

    // Storage write, no reset needed
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointer and count update with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            end
            count <= count_nxt;
        end
    end

endmodule

// File: rtl/tx_serializer.sv
// Module: shift register that sends one frame per byte: start low, data
// bits LSB first, stop high. Each bit lasts OVS enabled ticks.
// Assumes: ovs_tick is a one-cycle enable from an external baud generator.
// A byte is taken only when idle, data is held and cts_ok is high.
module tx_serializer #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    localparam int FRAME = DATA_W + 2,
    localparam int BW    = $clog2(FRAME),
    localparam int OW    = $clog2(OVS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovs_tick,
    input  logic              cts_ok,
    input  logic              have_data,
    input  logic [DATA_W-1:0] data_in,
    output logic              pop,
    output logic              busy,
    output logic              txd
);
    import uart_tx_pkg::*;

    ser_state_t       state;
    logic [FRAME-1:0] shreg;
    logic [BW-1:0]    bitcnt;
    logic [OW-1:0]    tickcnt;
    logic             bit_end;

    // Start a frame only when idle, fed and allowed by flow control
    assign pop     = (state == SER_IDLE) && have_data && cts_ok;
    assign busy    = (state == SER_SHIFT);
    assign bit_end = ovs_tick && (tickcnt == OW'(OVS - 1));

    // Frame sequencing: load, per-bit shift, stop-bit completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SER_IDLE;
            shreg   <= '1;
            bitcnt  <= '0;
            tickcnt <= '0;
            txd     <= 1'b1;
        end else begin
            case (state)
                SER_IDLE: begin
                    if (pop) begin
                        shreg   <= {1'b1, data_in, 1'b0};
                        bitcnt  <= '0;
                        tickcnt <= '0;
                        txd     <= 1'b0;
                        state   <= SER_SHIFT;
                    end
                end
                SER_SHIFT: begin
                    if (bit_end) begin
                        tickcnt <= '0;
                        if (bitcnt == BW'(FRAME - 1)) begin
                            txd   <= 1'b1;
                            state <= SER_IDLE;
                        end else begin
                            bitcnt <= bitcnt + BW'(1);
                            shreg  <= {1'b1, shreg[FRAME-1:1]};
                            txd    <= shreg[1];
                        end
                    end else if (ovs_tick) begin
                        tickcnt <= tickcnt + OW'(1);
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tx_irq_ctrl.sv
// Module: transmit-empty interrupt. Latches a pending bit on drain-to-empty
// in both modes, and on a fall below the selected threshold in FIFO mode.
// A read pulse clears it. A same-cycle event takes priority over the clear.
// Assumes: count and count_nxt come from the holding stage in the same cycle.
module tx_irq_ctrl #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] count_nxt,
    input  logic          isr_rd,
    input  logic          irq_en,
    output logic          pending,
    output logic          irq
);
    import uart_tx_pkg::*;

    int   level;
    logic ev_empty;
    logic ev_level;

    // Event detection on the edge about to be taken
    always_comb begin
        level    = trig_level(trig_sel, DEPTH);
        ev_empty = (count != '0) && (count_nxt == '0);
        ev_level = fifo_en && (int'(count) >= level) && (int'(count_nxt) < level);
    end

    // Pending bit: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (ev_empty || ev_level) begin
            pending <= 1'b1;
        end else if (isr_rd) begin
            pending <= 1'b0;
        end
    end

    assign irq = pending && irq_en;

endmodule

// File: rtl/uart_tx_path.sv
// Module: top of the UART transmit path. Holding stage, serializer and
// interrupt logic, with the two empty flags derived here.
// Assumes: ovs_tick comes from an external divider at 16x the bit rate.
module uart_tx_path #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int OVS    = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovs_tick,
    input  logic              fifo_en,
    input  logic [1:0]        trig_sel,
    input  logic              irq_en,
    input  logic              cts_ok,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              isr_rd,
    output logic              txd,
    output logic              hold_empty,
    output logic              xmit_empty,
    output logic              irq
);

    logic [DATA_W-1:0] head_data;
    logic [CW-1:0]     hold_count;
    logic [CW-1:0]     hold_count_nxt;
    logic              ser_pop;
    logic              ser_busy;
    logic              irq_pend;

    tx_hold_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pop       (ser_pop),
        .rd_data   (head_data),
        .count     (hold_count),
        .count_nxt (hold_count_nxt)
    );

    tx_serializer #(.DATA_W(DATA_W), .OVS(OVS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovs_tick  (ovs_tick),
        .cts_ok    (cts_ok),
        .have_data (hold_count != '0),
        .data_in   (head_data),
        .pop       (ser_pop),
        .busy      (ser_busy),
        .txd       (txd)
    );

    tx_irq_ctrl #(.DEPTH(DEPTH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .trig_sel  (trig_sel),
        .count     (hold_count),
        .count_nxt (hold_count_nxt),
        .isr_rd    (isr_rd),
        .irq_en    (irq_en),
        .pending   (irq_pend),
        .irq       (irq)
    );

    // Status flags from the holding count and the serializer state
    assign hold_empty = (hold_count == '0);
    assign xmit_empty = hold_empty && !ser_busy;

endmodule

// File: rtl/uart_tx_path_chk.sv
// Checker: temporal properties of the transmit path, bound into the top.
module uart_tx_path_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          cts_ok,
    input logic          wr_en,
    input logic          txd,
    input logic          xmit_empty,
    input logic          busy,
    input logic          pop,
    input logic          pending,
    input logic [CW-1:0] count
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_empty |-> txd); // R2
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && count == CW'(DEPTH) && wr_en && !pop) |=> count == CW'(DEPTH)); // R3
    AST_XMIT_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xmit_empty) |-> $past(busy)); // R6
    AST_CTS_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!cts_ok && !busy) |=> !busy); // R11
    AST_PENDING_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> ($past(count) != '0)); // R7

endmodule

bind uart_tx_path uart_tx_path_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .cts_ok     (cts_ok),
    .wr_en      (wr_en),
    .txd        (txd),
    .xmit_empty (xmit_empty),
    .busy       (ser_busy),
    .pop        (ser_pop),
    .pending    (irq_pend),
    .count      (hold_count)
);

// File: tb/uart_tx_path_test.sv
module uart_tx_path_test;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 2;
    localparam int DEPTH      = 16;

    logic       clk;
    logic       rst_n;
    logic       ovs_tick;
    logic       fifo_en;
    logic [1:0] trig_sel;
    logic       irq_en;
    logic       cts_ok;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       isr_rd;
    logic       txd;
    logic       hold_empty;
    logic       xmit_empty;
    logic       irq;

    int n_cmp = 0;
    int n_err = 0;

    uart_tx_path uut (
        .clk(clk), .rst_n(rst_n), .ovs_tick(ovs_tick), .fifo_en(fifo_en),
        .trig_sel(trig_sel), .irq_en(irq_en), .cts_ok(cts_ok), .wr_en(wr_en),
        .wr_data(wr_data), .isr_rd(isr_rd), .txd(txd), .hold_empty(hold_empty),
        .xmit_empty(xmit_empty), .irq(irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Oversampling tick, one cycle in TDIV
    int tdiv_cnt = 0;
    always @(negedge clk) begin
        tdiv_cnt = (tdiv_cnt + 1) % TDIV;
        ovs_tick = (tdiv_cnt == 0);
    end

    // Bench model built from the requirements
    int         m_cnt;
    logic [7:0] m_q[$];
    logic [7:0] sent_q[$];
    bit         m_busy;
    logic [9:0] m_frame;
    int         m_bit;
    int         m_tick;
    bit         m_txd;
    bit         m_pend;

    function automatic int level_of(input logic [1:0] s);
        case (s)
            2'd0: return 4;
            2'd1: return 8;
            2'd2: return 12;
            default: return 14;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_q.delete(); sent_q.delete(); m_busy = 0;
            m_bit = 0; m_tick = 0; m_txd = 1; m_pend = 0;
        end else begin
            int  cap;
            bit  do_pop;
            bit  do_push;
            int  nxt;
            bit  ev;
            logic [7:0] d;
            cap     = fifo_en ? DEPTH : 1;
            do_pop  = !m_busy && m_cnt > 0 && cts_ok;
            do_push = wr_en && m_cnt < cap;
            nxt     = m_cnt + int'(do_push) - int'(do_pop);
            ev      = (m_cnt != 0 && nxt == 0) ||
                      (fifo_en && m_cnt >= level_of(trig_sel) && nxt < level_of(trig_sel));
            if (do_pop) begin
                d = m_q.pop_front();
                sent_q.push_back(d);
                m_frame = {1'b1, d, 1'b0};
                m_busy = 1; m_bit = 0; m_tick = 0; m_txd = 0;
            end else if (m_busy && ovs_tick) begin
                if (m_tick == 15) begin
                    m_tick = 0;
                    if (m_bit == 9) begin
                        m_busy = 0; m_txd = 1;
                    end else begin
                        m_bit++; m_txd = m_frame[m_bit];
                    end
                end else begin
                    m_tick++;
                end
            end
            if (do_push) m_q.push_back(wr_data);
            m_pend = ev ? 1'b1 : (isr_rd ? 1'b0 : m_pend);
            m_cnt  = nxt;
        end
    end

    // Per-cycle comparison of every output against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 txd", txd, m_txd);
            chk(fifo_en ? "R5 hold_empty" : "R4 hold_empty", hold_empty, m_cnt == 0);
            chk("R6 xmit_empty", xmit_empty, (m_cnt == 0) && !m_busy);
            chk("R9 irq", irq, m_pend && irq_en);
        end
    end

    // Serial decoder independent of the model's shifter
    bit         mon_act = 0;
    int         mon_ticks;
    logic [7:0] mon_byte;
    int         mon_frames = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mon_act = 0;
        end else if (!mon_act) begin
            if (txd === 1'b0) begin
                mon_act = 1;
                mon_ticks = ovs_tick ? 1 : 0;
            end
        end else if (ovs_tick) begin
            mon_ticks++;
            if (mon_ticks >= 8 && (mon_ticks - 8) % 16 == 0) begin
                int idx;
                idx = (mon_ticks - 8) / 16;
                if (idx == 0) begin
                    chk("R2 start bit", txd, 0);
                end else if (idx <= 8) begin
                    mon_byte[idx-1] = txd;
                end else begin
                    chk("R2 stop bit", txd, 1);
                    if (sent_q.size() == 0) begin
                        chk("R12 unexpected frame", 1, 0);
                    end else begin
                        chk("R12 byte order", mon_byte, sent_q.pop_front());
                    end
                    mon_frames++;
                    mon_act = 0;
                end
            end
        end
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic drain();
        do @(negedge clk); while (!(xmit_empty && !mon_act));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        int f0;
        void'($urandom(32'h5EED_0042));
        rst_n = 0; fifo_en = 0; trig_sel = 0; irq_en = 0; cts_ok = 1;
        wr_en = 0; wr_data = 0; isr_rd = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", txd, 1);
        chk("R1 hold_empty", hold_empty, 1);
        chk("R1 xmit_empty", xmit_empty, 1);
        chk("R1 irq", irq, 0);

        // R4: flag rises with the start bit in single-register mode
        @(negedge clk); wr_en = 1; wr_data = 8'hA5;
        @(negedge clk); wr_en = 0;
        chk("R4 held before load", hold_empty, 0);
        @(negedge clk);
        chk("R4 empty at load", hold_empty, 1);
        chk("R4 start at load", txd, 0);
        drain();

        // R3 single mode: a write while the register is full is dropped
        cts_ok = 0; f0 = mon_frames;
        wr(8'h11); wr(8'h22);
        cts_ok = 1; drain();
        chk("R3 single capacity", mon_frames - f0, 1);

        // R3 FIFO mode: 18 writes, 16 kept
        fifo_en = 1; cts_ok = 0; f0 = mon_frames;
        for (int i = 0; i < 18; i++) wr(8'(i * 37 + 3));
        cts_ok = 1; drain();
        chk("R3 fifo capacity", mon_frames - f0, 16);

        // R11: flow control stops between frames only
        f0 = mon_frames;
        wr(8'h3C); wr(8'hC3);
        repeat (40) @(negedge clk);
        cts_ok = 0;
        repeat (800) @(negedge clk);
        chk("R11 frame completed", mon_frames - f0, 1);
        chk("R11 next held", hold_empty, 0);
        cts_ok = 1; drain();
        chk("R11 resumed", mon_frames - f0, 2);

        // R8/R10/R7/R9: threshold, read clear, empty
        @(negedge clk); isr_rd = 1; @(negedge clk); isr_rd = 0;
        trig_sel = 0; irq_en = 1; cts_ok = 0;
        for (int i = 0; i < 6; i++) wr(8'(8'h40 + i));
        chk("R10 cleared", irq, 0);
        cts_ok = 1;
        do @(negedge clk); while (m_cnt != 3);
        chk("R8 below level 4", irq, 1);
        isr_rd = 1; @(negedge clk); isr_rd = 0;
        chk("R10 read clears", irq, 0);
        irq_en = 0;
        do @(negedge clk); while (m_cnt != 0);
        chk("R9 gated off", irq, 0);
        irq_en = 1; @(negedge clk);
        chk("R7 pending on empty held", irq, 1);
        drain();

        // Random phase: bursts, reads, flow control and mode changes
        for (int c = 0; c < 30000; c++) begin
            @(negedge clk);
            wr_en   = ($urandom % 100) < 7;
            wr_data = 8'($urandom);
            isr_rd  = ($urandom % 100) < 20;
            if (($urandom % 100) < 2) irq_en = ~irq_en;
            if (($urandom % 1000) < 4) cts_ok = ~cts_ok;
            if (($urandom % 1000) < 3) trig_sel = 2'($urandom);
            if (($urandom % 2000) < 2) fifo_en = ~fifo_en;
        end
        @(negedge clk); wr_en = 0; isr_rd = 0; cts_ok = 1;
        drain();
        chk("R12 all sent bytes decoded", sent_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule